// File: doc/BRIEF.md
# Unaligned Wide Load Aligner

This block sits between a memory that returns one aligned 128-bit row per read and the load path of a SIMD datapath. It lets a 64-bit (four halfword) or 128-bit (eight halfword) load start at any halfword address, where a plain wide load would need an address that is a multiple of its own size. Addresses are in halfword units. The low three bits give the lane offset inside a row, and the remaining bits give the row index.

The block keeps the last row it fetched. When a load crosses into the next row, the result is built from the kept row and the newly read one. A stream of loads that walk forward through memory therefore costs one row read per result. The first crossing load after reset, and any crossing load that does not continue from the kept row, must first prime the buffer. Priming costs one read that produces no result and stalls the request port for one cycle. A load that fits inside a single row needs only that row. At lane offset zero the row passes through unshifted. The block serves reads only.

The memory is assumed to answer a read in the cycle after `mem_rd_en` is high.

Top module: `ualb_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `out_valid` is 0 and `mem_rd_en` is 0, and the buffer holds no row.
- R2: For a 128-bit load (`req_quad`=1) at halfword address A, bits [16i+15:16i] of `out_data` hold the memory halfword at A+i, for i = 0..7. Within a row, halfword k sits at bits [16k+15:16k].
- R3: For a 64-bit load (`req_quad`=0), lanes 0..3 of `out_data` hold the halfwords at A..A+3, and bits [127:64] are zero.
- R4: A load is crossing when its lane offset plus its length (4 or 8) exceeds 8. A crossing load accepted with an empty buffer reads row r in its acceptance cycle and row r+1 in the next cycle. In that next cycle `req_ready` is 0. The result is valid in the third cycle after acceptance.
- R5: A crossing load whose row r equals the kept row reads only row r+1. It causes no stall, and its result is valid in the second cycle after acceptance. Back-to-back forward loads give one result per cycle.
- R6: A crossing load whose row differs from the kept row discards the kept row and primes again, exactly as in R4.
- R7: A non-crossing load reads only its own row, causes no stall, and gives its result in the second cycle after acceptance. At lane offset 0 the row is returned unshifted. Afterwards the kept row is that row.
- R8: `mem_rd_en` is high only in a cycle where a request is accepted, or in the stall cycle of a prime. Each such cycle reads exactly one row.
- R9: A request presented while `req_ready` is 0 is ignored: it causes no read and no result.
- R10: Row indices wrap, so the row after the last row is row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Start halfword address |
| req_quad | input | 1 | 1 = 128-bit load, 0 = 64-bit load |
| mem_rd_en | output | 1 | Row read strobe |
| mem_rd_row | output | ADDR_W-3 | Row index to read |
| mem_rd_data | input | 128 | Row data, one cycle after the strobe |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Aligned load result |

## Verification
A load accepted in cycle c that needs no priming drives `out_valid` in cycle c+2. This covers one memory cycle and one output register. A priming load returns its result in cycle c+3 and holds `req_ready` low in cycle c+1. The reference model schedules each expected result into the exact cycle those counts give. It compares `out_valid`, `out_data` and `req_ready` once per cycle on the falling edge, and checks `mem_rd_en` just after the inputs of the cycle are driven. As a result, a result that arrives one cycle early or late, an extra read, or a missing stall each fails a check in the cycle it happens.

// File: rtl/ualb_pkg.sv
package ualb_pkg;
  localparam int LANE_W = 16;
  localparam int LANES  = 8;
  localparam int ROW_W  = LANE_W * LANES;
  localparam int OFF_W  = $clog2(LANES);

  // a load crosses a row boundary when its last lane lies in the next row
  function automatic logic crosses_row(input logic [OFF_W-1:0] off, input logic quad);
    int len;
    len = quad ? LANES : LANES / 2;
    return (int'(off) + len) > LANES;
  endfunction

  // pick LANES lanes starting at lane 'off' out of the pair {hi, lo}
  function automatic logic [ROW_W-1:0] pick_lanes(input logic [ROW_W-1:0] lo,
                                                  input logic [ROW_W-1:0] hi,
                                                  input logic [OFF_W-1:0] off,
                                                  input logic quad);
    logic [2*ROW_W-1:0] win;
    logic [ROW_W-1:0]   res;
    win = {hi, lo} >> (int'(off) * LANE_W);
    res = win[ROW_W-1:0];
    if (!quad) res[ROW_W-1:ROW_W/2] = '0;
    return res;
  endfunction
endpackage

// File: rtl/ualb_ctrl.sv
module ualb_ctrl
  import ualb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_quad,
  output logic                    mem_rd_en,
  output logic [ADDR_W-OFF_W-1:0] mem_rd_row,
  output logic                    issue_serve,
  output logic                    issue_prime,
  output logic [OFF_W-1:0]        iss_off,
  output logic                    iss_quad,
  output logic                    iss_span
);
  localparam int RA = ADDR_W - OFF_W;

  logic          pend_q;
  logic [RA-1:0] pend_row_q;
  logic [OFF_W-1:0] pend_off_q;
  logic          pend_quad_q;
  logic          tag_v_q;
  logic [RA-1:0] tag_row_q;

  logic [RA-1:0]    req_row;
  logic [OFF_W-1:0] req_off;
  logic accept, req_span, seq_hit;

  assign req_row   = req_addr[ADDR_W-1:OFF_W];
  assign req_off   = req_addr[OFF_W-1:0];
  assign req_ready = !pend_q;
  assign accept    = req_valid && req_ready;
  assign req_span  = crosses_row(req_off, req_quad);
  assign seq_hit   = tag_v_q && (tag_row_q == req_row);
  assign issue_prime = accept && req_span && !seq_hit;

  always_comb begin
    mem_rd_en   = 1'b0;
    mem_rd_row  = '0;
    issue_serve = 1'b0;
    iss_off     = '0;
    iss_quad    = 1'b0;
    iss_span    = 1'b0;
    if (pend_q) begin
      mem_rd_en   = 1'b1;
      mem_rd_row  = pend_row_q + 1'b1;
      issue_serve = 1'b1;
      iss_off     = pend_off_q;
      iss_quad    = pend_quad_q;
      iss_span    = 1'b1;
    end else if (accept) begin
      mem_rd_en   = 1'b1;
      mem_rd_row  = (req_span && !issue_prime) ? req_row + 1'b1 : req_row;
      issue_serve = !issue_prime;
      iss_off     = req_off;
      iss_quad    = req_quad;
      iss_span    = req_span;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_row_q  <= '0;
      pend_off_q  <= '0;
      pend_quad_q <= 1'b0;
      tag_v_q     <= 1'b0;
      tag_row_q   <= '0;
    end else begin
      pend_q <= issue_prime;
      if (issue_prime) begin
        pend_row_q  <= req_row;
        pend_off_q  <= req_off;
        pend_quad_q <= req_quad;
      end
      if (mem_rd_en) begin
        tag_v_q   <= 1'b1;
        tag_row_q <= mem_rd_row;
      end
    end
  end
endmodule

// File: rtl/ualb_merge.sv
module ualb_merge
  import ualb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_serve,
  input  logic             issue_prime,
  input  logic [OFF_W-1:0] iss_off,
  input  logic             iss_quad,
  input  logic             iss_span,
  input  logic [ROW_W-1:0] mem_rd_data,
  output logic             out_valid,
  output logic [ROW_W-1:0] out_data,
  output logic             out_quad
);
  logic             s_serve, s_prime, s_quad, s_span;
  logic [OFF_W-1:0] s_off;
  logic [ROW_W-1:0] held_q;
  logic [ROW_W-1:0] result;
  logic             bypass;

  assign bypass = (s_off == '0);

  always_comb begin
    if (bypass)      result = pick_lanes(mem_rd_data, mem_rd_data, '0, s_quad);
    else if (s_span) result = pick_lanes(held_q, mem_rd_data, s_off, s_quad);
    else             result = pick_lanes(mem_rd_data, mem_rd_data, s_off, s_quad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_serve   <= 1'b0;
      s_prime   <= 1'b0;
      s_off     <= '0;
      s_quad    <= 1'b0;
      s_span    <= 1'b0;
      held_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_quad  <= 1'b0;
    end else begin
      s_serve <= issue_serve;
      s_prime <= issue_prime;
      s_off   <= iss_off;
      s_quad  <= iss_quad;
      s_span  <= iss_span;
      if (s_serve || s_prime) held_q <= mem_rd_data;
      out_valid <= s_serve;
      if (s_serve) begin
        out_data <= result;
        out_quad <= s_quad;
      end
    end
  end
endmodule

// File: rtl/ualb_top.sv
module ualb_top
  import ualb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_quad,
  output logic                    mem_rd_en,
  output logic [ADDR_W-OFF_W-1:0] mem_rd_row,
  input  logic [ROW_W-1:0]        mem_rd_data,
  output logic                    out_valid,
  output logic [ROW_W-1:0]        out_data
);
  logic             issue_serve, issue_prime, iss_quad, iss_span, out_quad;
  logic [OFF_W-1:0] iss_off;

  ualb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_quad(req_quad), .mem_rd_en(mem_rd_en),
    .mem_rd_row(mem_rd_row), .issue_serve(issue_serve), .issue_prime(issue_prime),
    .iss_off(iss_off), .iss_quad(iss_quad), .iss_span(iss_span)
  );

  ualb_merge u_merge (
    .clk(clk), .rst_n(rst_n), .issue_serve(issue_serve), .issue_prime(issue_prime),
    .iss_off(iss_off), .iss_quad(iss_quad), .iss_span(iss_span),
    .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_data(out_data),
    .out_quad(out_quad)
  );
endmodule

// File: rtl/ualb_chk.sv
module ualb_chk
  import ualb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    mem_rd_en,
  input logic [ADDR_W-OFF_W-1:0] mem_rd_row,
  input logic                    out_valid,
  input logic [ROW_W-1:0]        out_data,
  input logic                    out_quad,
  input logic                    issue_serve,
  input logic                    issue_prime
);
  localparam int RA = ADDR_W - OFF_W;

  AST_PRIME_NEXT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    issue_prime |=> (!req_ready && mem_rd_en && mem_rd_row == RA'($past(mem_rd_row) + 1'b1))); // R4

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready); // R4

  AST_SERVE_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    issue_serve |=> ##1 out_valid); // R5

  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(issue_serve, 2)); // R9

  AST_DUAL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_quad) |-> out_data[ROW_W-1:ROW_W/2] == '0); // R3

  AST_READ_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ((req_valid && req_ready) || !req_ready)); // R8
endmodule

bind ualb_top ualb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_en(mem_rd_en), .mem_rd_row(mem_rd_row), .out_valid(out_valid),
  .out_data(out_data), .out_quad(out_quad), .issue_serve(issue_serve),
  .issue_prime(issue_prime)
);

// File: tb/sim_ualb_top.sv
module sim_ualb_top;
  localparam int ADDR_W = 16;
  localparam int RA     = ADDR_W - 3;
  localparam int unsigned AMASK = (1 << ADDR_W) - 1;
  localparam int unsigned RMASK = (1 << RA) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_quad = 1'b0;
  logic mem_rd_en;
  logic [RA-1:0] mem_rd_row;
  logic [127:0] mem_rd_data = '0;
  logic out_valid;
  logic [127:0] out_data;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  ualb_top #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_quad(req_quad), .mem_rd_en(mem_rd_en),
    .mem_rd_row(mem_rd_row), .mem_rd_data(mem_rd_data), .out_valid(out_valid),
    .out_data(out_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] hw_at(input int unsigned h);
    int unsigned a;
    a = h & AMASK;
    return 16'((a * 40503 + 4660) ^ (a >> 3));
  endfunction

  function automatic logic [127:0] row_data(input int unsigned row);
    logic [127:0] d;
    for (int i = 0; i < 8; i++) d[i*16 +: 16] = hw_at(row * 8 + i);
    return d;
  endfunction

  // memory with one cycle read latency
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= row_data(int'(mem_rd_row));

  // reference model state
  bit m_v = 0;
  int unsigned m_row = 0;
  int stall_cyc = -10;
  logic [127:0] exp_data [int];
  string exp_tag [int];

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input bit v, input int unsigned addr, input bit q);
    bit exp_ready, acc, exp_rd;
    int unsigned r, off, len;
    bit span, prime;
    logic [127:0] e;
    string tag;
    exp_ready = (cyc != stall_cyc);
    check(req_ready == exp_ready, "R4 ready", 128'(req_ready), 128'(exp_ready));
    if (exp_data.exists(cyc)) begin
      check(out_valid == 1'b1, exp_tag[cyc], 128'(out_valid), 128'd1);
      check(out_data == exp_data[cyc], exp_tag[cyc], out_data, exp_data[cyc]);
      exp_data.delete(cyc);
      exp_tag.delete(cyc);
    end else begin
      check(out_valid == 1'b0, "R9 no result", 128'(out_valid), 128'd0);
    end
    req_valid = v;
    req_addr  = ADDR_W'(addr);
    req_quad  = q;
    acc = v && exp_ready;
    if (acc) begin
      r = (addr & AMASK) >> 3;
      off = addr & 7;
      len = q ? 8 : 4;
      span = (off + len) > 8;
      prime = span && !(m_v && m_row == r);
      e = '0;
      for (int i = 0; i < 8; i++) if (i < len) e[i*16 +: 16] = hw_at(addr + i);
      tag = q ? "R2" : "R3";
      if (prime) tag = {tag, m_v ? "/R6" : "/R4"};
      else tag = {tag, span ? "/R5" : "/R7"};
      if (span && r == RMASK) tag = {tag, "/R10"};
      exp_data[cyc + (prime ? 3 : 2)] = e;
      exp_tag[cyc + (prime ? 3 : 2)] = tag;
      m_v = 1;
      m_row = span ? ((r + 1) & RMASK) : r;
      if (prime) stall_cyc = cyc + 1;
    end
    exp_rd = acc || (cyc == stall_cyc);
    #1;
    check(mem_rd_en == exp_rd, exp_ready ? "R8 read" : "R9 read", 128'(mem_rd_en), 128'(exp_rd));
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) if (cyc == 60000) begin
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int unsigned next_a;
    bit nq;
    repeat (3) @(negedge clk);
    check(req_ready && !out_valid && !mem_rd_en, "R1 in reset", {out_valid, mem_rd_en, req_ready}, 128'b001);
    rst_n = 1'b1;
    check(req_ready && !out_valid && !mem_rd_en, "R1 after reset", {out_valid, mem_rd_en, req_ready}, 128'b001);
    @(negedge clk);
    // forward stream of 128-bit loads at offset 3, first one primes
    step(1, 'h13, 1);
    step(1, 'h777, 0);           // presented during stall: ignored (R9)
    for (int k = 1; k < 6; k++) step(1, 'h13 + 8 * k, 1);
    step(0, 0, 0);
    step(1, 'h105, 1);           // jump: flush and prime (R6)
    step(0, 0, 0);
    step(1, 'h10D, 0);           // continues from kept row (R5)
    step(1, 'h111, 0);           // fits in one row (R7)
    step(1, 'h200, 1);           // offset zero bypass (R7)
    step(1, 'h204, 0);
    step(1, 'h207, 1);           // kept row from a single-row load (R5)
    step(0, 0, 0);
    step(1, 'hFFFB, 1);          // last row, wraps to row 0 (R10)
    step(1, 'h1234, 1);
    step(1, 'h0003, 1);
    repeat (4) step(0, 0, 0);
    next_a = 'h40;
    nq = 1;
    for (int k = 0; k < 500; k++) begin
      if ($urandom_range(0, 4) == 0) step(0, 0, 0);
      else begin
        if ($urandom_range(0, 2) == 0) begin
          next_a = $urandom & AMASK;
          nq = $urandom_range(0, 1);
        end
        step(1, next_a, nq);
        next_a = (next_a + (nq ? 8 : 4)) & AMASK;
      end
    end
    repeat (6) step(0, 0, 0);
    check(exp_data.num() == 0, "R5 pending results", 128'(exp_data.num()), 128'd0);
    summary();
    $finish;
  end
endmodule